// File: doc/BRIEF.md
# Oscillator Range Change Sequencer

This block moves an oscillator's two control fields from their present values to requested ones. The fields are a 4-bit coarse range code and a 3-bit fine-step code. Some jumps between coarse ranges can briefly stop the oscillator, for roughly 20 µs. Other jumps can push it past the highest frequency the system allows. To avoid both, the sequencer breaks such a move into safe intermediate settings. It applies one setting per step and holds each one for a programmable number of reference clock cycles before it takes the next step.

A request is a single-cycle `req_valid` that carries the target range and fine step. It is accepted only while the block is idle. The sequencer raises `busy` while intermediate settings are being held. It pulses `done` in the cycle the final target values first appear on the control outputs. The oscillator itself is not part of the block. The outputs drive its control register fields directly.

Top module: `osc_range_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `range_out` is RESET_RANGE (default 7), `fine_out` is RESET_FINE (default 3), and `busy` and `done` are 0.
- R2: When the target range is 13, 14 or 15 and the current range is 12 or above, the target range and fine step are applied together in a single step.
- R3: When the current range is 14 or 15 and the target range is 0 to 12, the first step sets range 13 and keeps the current fine step. The second step applies the target range and fine step.
- R4: When the current range is 0 to 13 and the target range is 0 to 12, the target is applied in a single step.
- R5: When the current range is below 12 and the target range is 14 or 15, the move takes three steps. The first keeps the current range with fine step 0. The second sets the target range with fine step 0. The third applies the target fine step.
- R6: The first step appears on the outputs in the cycle after the accepting clock edge. Each later step appears exactly max(`settle_cycles`,1) cycles after the step before it.
- R7: `done` is high for exactly one cycle, the cycle in which the final setting first appears. `busy` is high from the cycle after acceptance of a multi-step move until `done`, and is low in the `done` cycle.
- R8: A request presented while `busy` is high is ignored. The move in progress and its final values are unchanged.
- R9: While idle with no request, `range_out` and `fine_out` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Single-cycle request strobe |
| req_range | input | 4 | Target coarse range |
| req_fine | input | 3 | Target fine step |
| settle_cycles | input | 8 | Hold time per step in clock cycles (0 behaves as 1) |
| range_out | output | 4 | Coarse range control field |
| fine_out | output | 3 | Fine-step control field |
| busy | output | 1 | Multi-step move in progress |
| done | output | 1 | One-cycle pulse when the final values are applied |

## Verification
The assertions check four properties on every cycle. The range never drops from 14 or 15 straight to 12 or below. Any climb from below 12 to above 13 happens with the fine step at 0. `done` never coincides with `busy`. The outputs never change while the block is idle and unrequested. Only the bench scenarios can show the exact order of settings for each of the 256 current/target range pairs, the hold length of every step under several settle values, and that a request during a move leaves that move untouched.

// File: rtl/osc_range_pkg.sv
package osc_range_pkg;

    localparam int RANGE_W = 4;
    localparam int FINE_W  = 3;
    localparam int MAX_STEPS = 3;
    localparam int STEP_IDX_W = $clog2(MAX_STEPS);

    localparam logic [RANGE_W-1:0] PIVOT_RANGE = 4'd13;
    localparam logic [RANGE_W-1:0] TOP_BAND_LO = 4'd14;
    localparam logic [RANGE_W-1:0] LOW_BAND_HI = 4'd12;
    localparam logic [RANGE_W-1:0] CLIMB_BELOW = 4'd12;

    typedef struct packed {
        logic [RANGE_W-1:0] rng;
        logic [FINE_W-1:0]  fine;
    } osc_setting_t;

    typedef struct packed {
        logic [STEP_IDX_W-1:0]         nsteps;
        osc_setting_t [MAX_STEPS-1:0]  step;
    } step_plan_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    function automatic osc_setting_t mk_setting(logic [RANGE_W-1:0] r, logic [FINE_W-1:0] f);
        osc_setting_t s;
        s.rng  = r;
        s.fine = f;
        return s;
    endfunction

    function automatic step_plan_t build_plan(osc_setting_t cur, osc_setting_t tgt);
        step_plan_t p;
        p = '0;
        if (tgt.rng >= TOP_BAND_LO && cur.rng < CLIMB_BELOW) begin
            p.step[0] = mk_setting(cur.rng, '0);
            p.step[1] = mk_setting(tgt.rng, '0);
            p.step[2] = tgt;
            p.nsteps  = 2'd3;
        end else if (tgt.rng <= LOW_BAND_HI && cur.rng >= TOP_BAND_LO) begin
            p.step[0] = mk_setting(PIVOT_RANGE, cur.fine);
            p.step[1] = tgt;
            p.step[2] = tgt;
            p.nsteps  = 2'd2;
        end else begin
            p.step[0] = tgt;
            p.step[1] = tgt;
            p.step[2] = tgt;
            p.nsteps  = 2'd1;
        end
        return p;
    endfunction

endpackage

// File: rtl/osc_range_plan.sv
module osc_range_plan
    import osc_range_pkg::*;
(
    input  osc_setting_t cur,
    input  osc_setting_t tgt,
    output step_plan_t   plan
);
    always_comb plan = build_plan(cur, tgt);
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] hold,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hold_eff;

    always_comb hold_eff = (hold == '0) ? CNT_W'(1) : hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_W'(1);
        end else if (load) begin
            cnt <= hold_eff;
        end else if (run && cnt != CNT_W'(1)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    always_comb expire = run && (cnt == CNT_W'(1));
endmodule

// File: rtl/osc_range_seq.sv
module osc_range_seq
    import osc_range_pkg::*;
#(
    parameter int                 SETTLE_W    = 8,
    parameter logic [RANGE_W-1:0] RESET_RANGE = 4'd7,
    parameter logic [FINE_W-1:0]  RESET_FINE  = 3'd3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [RANGE_W-1:0]  req_range,
    input  logic [FINE_W-1:0]   req_fine,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic [RANGE_W-1:0]  range_out,
    output logic [FINE_W-1:0]   fine_out,
    output logic                busy,
    output logic                done
);
    seq_state_t            state;
    osc_setting_t          cur_q;
    osc_setting_t          tgt_in;
    step_plan_t            plan_new;
    step_plan_t            plan_q;
    logic [STEP_IDX_W-1:0] idx_q;
    logic                  accept;
    logic                  expire;
    logic                  last_step;
    logic                  timer_load;
    logic                  done_q;

    always_comb tgt_in = mk_setting(req_range, req_fine);

    osc_range_plan u_plan (
        .cur  (cur_q),
        .tgt  (tgt_in),
        .plan (plan_new)
    );

    always_comb begin
        accept     = (state == SEQ_IDLE) && req_valid;
        last_step  = (idx_q == plan_q.nsteps - STEP_IDX_W'(1));
        timer_load = (accept && plan_new.nsteps != STEP_IDX_W'(1))
                   || (state == SEQ_RUN && expire && !last_step);
    end

    osc_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (timer_load),
        .run    (state == SEQ_RUN),
        .hold   (settle_cycles),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            cur_q  <= mk_setting(RESET_RANGE, RESET_FINE);
            plan_q <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        plan_q <= plan_new;
                        cur_q  <= plan_new.step[0];
                        if (plan_new.nsteps == STEP_IDX_W'(1)) begin
                            done_q <= 1'b1;
                        end else begin
                            state <= SEQ_RUN;
                            idx_q <= STEP_IDX_W'(1);
                        end
                    end
                end
                SEQ_RUN: begin
                    if (expire) begin
                        cur_q <= plan_q.step[idx_q];
                        if (last_step) begin
                            done_q <= 1'b1;
                            state  <= SEQ_IDLE;
                        end else begin
                            idx_q <= idx_q + STEP_IDX_W'(1);
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        range_out = cur_q.rng;
        fine_out  = cur_q.fine;
        busy      = (state == SEQ_RUN);
        done      = done_q;
    end
endmodule

// File: rtl/osc_range_seq_chk.sv
module osc_range_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [3:0] range_out,
    input logic [2:0] fine_out,
    input logic       busy,
    input logic       done
);
    // R3
    no_top_to_low_jump_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(range_out) >= 4'd14 && range_out != $past(range_out)) |-> (range_out >= 4'd13));

    // R5
    climb_with_fine_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(range_out) < 4'd12 && range_out > 4'd13) |-> (fine_out == 3'd0 && $past(fine_out) == 3'd0));

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9
    idle_outputs_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> ($stable(range_out) && $stable(fine_out)));
endmodule

bind osc_range_seq osc_range_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .range_out (range_out),
    .fine_out  (fine_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_osc_range_seq.sv
module tb_osc_range_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_range = '0;
    logic [2:0] req_fine = '0;
    logic [7:0] settle_cycles = 8'd1;
    logic [3:0] range_out;
    logic [2:0] fine_out;
    logic       busy;
    logic       done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [3:0] m_rng = 4'd7;
    logic [2:0] m_fine = 3'd3;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_range_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_range(req_range),
        .req_fine(req_fine), .settle_cycles(settle_cycles), .range_out(range_out),
        .fine_out(fine_out), .busy(busy), .done(done)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected step list: returns step count, fills r/f arrays
    function automatic int plan_exp(input logic [3:0] cr, input logic [2:0] cf,
                                    input logic [3:0] tr, input logic [2:0] tf,
                                    output logic [3:0] r[3], output logic [2:0] f[3],
                                    output string tag);
        if (cr >= 4'd14 && tr <= 4'd12) begin
            r[0] = 4'd13; f[0] = cf; r[1] = tr; f[1] = tf; tag = "R3"; return 2;
        end
        if (cr <= 4'd11 && tr >= 4'd14) begin
            r[0] = cr; f[0] = 3'd0; r[1] = tr; f[1] = 3'd0; r[2] = tr; f[2] = tf;
            tag = "R5"; return 3;
        end
        r[0] = tr; f[0] = tf;
        tag = (tr >= 4'd13) ? "R2" : "R4";
        return 1;
    endfunction

    task automatic run_req(input logic [3:0] tr, input logic [2:0] tf,
                           input logic [7:0] n, input bit inject);
        logic [3:0] er[3];
        logic [2:0] ef[3];
        string tag;
        int k;
        int neff;
        int last;
        int si;
        k = plan_exp(m_rng, m_fine, tr, tf, er, ef, tag);
        neff = (n == 0) ? 1 : int'(n);
        last = (k - 1) * neff;
        settle_cycles = n;
        req_range = tr;
        req_fine = tf;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int off = 0; off <= last + 1; off++) begin
            if (off > 0) @(negedge clk);
            si = off / neff;
            if (si > k - 1) si = k - 1;
            check({tag, "/R6 range"}, range_out, er[si]);
            check({tag, "/R6 fine"}, fine_out, ef[si]);
            check("R7 busy", busy, (off < last) ? 1 : 0);
            check("R7 done", done, (off == last) ? 1 : 0);
            req_valid = 1'b0;
            if (inject && off == 0 && k > 1) begin
                // R8: request while busy must be ignored
                req_range = ~tr;
                req_fine = ~tf;
                req_valid = 1'b1;
            end
        end
        req_valid = 1'b0;
        m_rng = tr;
        m_fine = tf;
        if (inject) begin
            check("R8 final range", range_out, tr);
            check("R8 final fine", fine_out, tf);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F0C_5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset range", range_out, 7);
        check("R1 reset fine", fine_out, 3);
        check("R1 reset busy", busy, 0);
        check("R1 reset done", done, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset range", range_out, 7);
        check("R1 post-reset fine", fine_out, 3);
        check("R1 post-reset busy", busy, 0);

        // Directed corners: zero settle, climb from 0 to 15, drop from 15 to 0
        run_req(4'd0, 3'd5, 8'd0, 1'b0);
        run_req(4'd15, 3'd7, 8'd0, 1'b1);
        run_req(4'd0, 3'd2, 8'd5, 1'b1);
        run_req(4'd12, 3'd4, 8'd2, 1'b0);
        run_req(4'd14, 3'd1, 8'd2, 1'b0);
        run_req(4'd14, 3'd1, 8'd3, 1'b0);

        // R9: idle without request keeps outputs unchanged
        repeat (4) @(negedge clk);
        check("R9 idle range", range_out, m_rng);
        check("R9 idle fine", fine_out, m_fine);

        // All 256 current/target range pairs with random fine steps and settle values
        for (int c = 0; c < 16; c++) begin
            for (int t = 0; t < 16; t++) begin
                run_req(4'(c), 3'($urandom), 8'($urandom_range(1, 4)), 1'b0);
                run_req(4'(t), 3'($urandom), 8'($urandom_range(0, 4)),
                        ($urandom_range(0, 3) == 0));
                @(negedge clk);
                check("R9 idle after move", range_out, t);
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule